// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches the recovered receive bit stream of a line interface, one bit per receive clock qualified by a valid strobe, and keeps a single registered loss-of-signal flag. Each bit is a mark or a space. The caller forms the mark input as the OR of the positive-rail and negative-rail pulses. The block only reports status. It never gates or alters the data path, so marks keep flowing downstream while the flag is high.

Raising and lowering the flag follow different rules. The flag goes high after a long unbroken run of spaces. It drops only when the line shows healthy density again: enough marks among the most recent window of valid bits, and no long run of zeros left inside that window. After reset the flag is high and all history is empty, so the line has to qualify afresh before the flag falls.

Top module: `los_detector`

## Requirements
- R1: While reset is held and on the first cycle after it is released, losFlag is 1.
- R2: When the 175th consecutive space is accepted on a valid cycle, losFlag is 1 one clock after that valid edge. After only 174 consecutive spaces the flag does not rise.
- R3: A mark accepted on a valid cycle restarts the space run, so 174 spaces, then a mark, then 174 more spaces do not raise the flag.
- R4: While losFlag is 1, it can fall only if at least 16 of the most recent 128 valid bits are marks (mark = 1 on markIn). Fifteen marks are not enough. Bit positions before reset count as spaces.
- R5: While losFlag is 1, it can also fall only once 128 or more valid bits have been accepted after the last zero of any run of 100 or more consecutive zeros. A run of 99 zeros imposes no such wait.
- R6: Cycles with bitValid = 0 have no effect on any count, whatever value markIn has.
- R7: Once losFlag is 0, it stays 0 through any pattern with fewer than 175 consecutive spaces, whatever the mark density.
- R8: When the clear conditions of R4 and R5 become true on a valid edge, losFlag is 0 one clock after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Qualifies markIn on this cycle |
| markIn | input | 1 | 1 = mark (either rail pulsed), 0 = space |
| losFlag | output | 1 | Registered loss-of-signal status |

## Verification
A corrupted window bit or mark counter moves the instant the flag falls. The error shows as a clear that comes one or more bits early or late against the arithmetic count of marks among the last 128 accepted bits, within one window length of the fault. A space-run counter that fails to restart or to saturate shows as a flag rising before or after the 175th space, or not at all. A stale zero-run hold shows when the flag clears before 128 bits have passed since a long zero run ended. Every bit is compared two clocks after it is presented, so a divergence is reported on the bit that causes it.

// File: rtl/los_pkg.sv
package los_pkg;
  // Strobes from the control side to the sliding-window datapath
  typedef struct packed {
    logic shift;  // accept one bit into the window
    logic mark;   // value of that bit
  } win_strobe_t;
endpackage

// File: rtl/los_window.sv
module los_window
  import los_pkg::*;
#(
  parameter int WIN_LEN   = 128,
  parameter int MIN_MARKS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  win_strobe_t strb,
  output logic        densityOk
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_MARKS);
  localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WIN_LEN);

  logic [WIN_LEN-1:0] window;
  logic [CNT_W-1:0]   markCnt;
  logic               leaving;

  assign leaving = window[WIN_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      window  <= '0;
      markCnt <= '0;
    end else if (strb.shift) begin
      window  <= {window[WIN_LEN-2:0], strb.mark};
      markCnt <= markCnt + CNT_W'(strb.mark) - CNT_W'(leaving);
    end
  end

  assign densityOk = markCnt >= MIN_V;

  // R4: the running count can never exceed the window length
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    markCnt <= WIN_V);

  // R6: an idle cycle leaves the window and its count untouched
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strb.shift |=> ($stable(markCnt) && $stable(window)));

  // R4: an accepted mark never lowers the count
  assert_mark_no_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (strb.shift && strb.mark) |=> markCnt >= $past(markCnt));
endmodule

// File: rtl/los_ctrl.sv
module los_ctrl
  import los_pkg::*;
#(
  parameter int SET_RUN  = 175,
  parameter int LONG_RUN = 100,
  parameter int WIN_LEN  = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bitValid,
  input  logic        markIn,
  input  logic        densityOk,
  output win_strobe_t strb,
  output logic        losFlag
);
  localparam int RUN_W  = $clog2(SET_RUN + 1);
  localparam int HOLD_W = $clog2(WIN_LEN + 1);
  localparam logic [RUN_W-1:0]  SET_V  = RUN_W'(SET_RUN);
  localparam logic [RUN_W-1:0]  LONG_V = RUN_W'(LONG_RUN);
  localparam logic [HOLD_W-1:0] WIN_V  = HOLD_W'(WIN_LEN);

  logic [RUN_W-1:0]  runCnt, runNext;
  logic [HOLD_W-1:0] holdCnt;
  logic              windowClean;

  assign strb.shift = bitValid;
  assign strb.mark  = markIn;

  // Saturating count of consecutive spaces
  always_comb begin
    if (markIn)               runNext = '0;
    else if (runCnt == SET_V) runNext = runCnt;
    else                      runNext = runCnt + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt  <= '0;
      holdCnt <= '0;
    end else if (bitValid) begin
      runCnt <= runNext;
      if (!markIn && runNext >= LONG_V) holdCnt <= WIN_V;
      else if (holdCnt != '0)           holdCnt <= holdCnt - HOLD_W'(1);
    end
  end

  assign windowClean = holdCnt == '0;

  always_ff @(posedge clk) begin
    if (rst)                                       losFlag <= 1'b1;
    else if (runCnt == SET_V)                      losFlag <= 1'b1;
    else if (losFlag && densityOk && windowClean)  losFlag <= 1'b0;
  end

  // R2: the flag rises only after a saturated space run
  assert_set_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(losFlag) |-> $past(runCnt) == SET_V);

  // R2: the space run never passes its saturation value
  assert_run_bound_R2: assert property (@(posedge clk) disable iff (rst)
    runCnt <= SET_V);

  // R3: an accepted mark restarts the space run
  assert_mark_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (bitValid && markIn) |=> runCnt == '0);

  // R5 / R8: the flag falls only with density met and no recent long run
  assert_clear_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(losFlag) |-> ($past(holdCnt) == '0 && $past(densityOk)));

  // R6: idle cycles leave the run state alone
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> ($stable(runCnt) && $stable(holdCnt)));
endmodule

// File: rtl/los_detector.sv
module los_detector #(
  parameter int SET_RUN   = 175,
  parameter int LONG_RUN  = 100,
  parameter int WIN_LEN   = 128,
  parameter int MIN_MARKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic markIn,
  output logic losFlag
);
  import los_pkg::*;

  win_strobe_t strb;
  logic        densityOk;

  los_ctrl #(
    .SET_RUN (SET_RUN),
    .LONG_RUN(LONG_RUN),
    .WIN_LEN (WIN_LEN)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .markIn   (markIn),
    .densityOk(densityOk),
    .strb     (strb),
    .losFlag  (losFlag)
  );

  los_window #(
    .WIN_LEN  (WIN_LEN),
    .MIN_MARKS(MIN_MARKS)
  ) u_window (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .densityOk(densityOk)
  );
endmodule

// File: tb/los_detector_test.sv
`timescale 1ns/1ps
module los_detector_test;
  logic clk = 1'b0;
  logic rst, bitValid, markIn;
  logic losFlag;

  los_detector uut (
    .clk(clk), .rst(rst), .bitValid(bitValid), .markIn(markIn), .losFlag(losFlag)
  );

  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  bit hist [8192];
  int nBits;
  int zRun;
  int lastLongIdx;
  bit expLos;

  task automatic check(input bit act, input bit exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: losFlag=%0b expected=%0b (bit %0d)", tag, act, exp, nBits);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; bitValid = 1'b0; markIn = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(losFlag, 1'b1, "R1 during reset");
    rst = 1'b0;
    nBits = 0; zRun = 0; lastLongIdx = -100000; expLos = 1'b1;
    @(negedge clk);
    check(losFlag, 1'b1, "R1 after release");
  endtask

  // Present one valid bit, then an idle cycle with the opposite markIn value
  task automatic sendBit(input bit b, input string tag);
    int marks;
    int lo;
    @(negedge clk);
    bitValid = 1'b1; markIn = b;
    @(negedge clk);
    bitValid = 1'b0; markIn = ~b;
    @(negedge clk);
    hist[nBits] = b;
    nBits++;
    zRun = b ? 0 : zRun + 1;
    if (!b && zRun >= 100) lastLongIdx = nBits - 1;
    marks = 0;
    lo = (nBits > 128) ? nBits - 128 : 0;
    for (int i = lo; i < nBits; i++) marks += hist[i];
    if (zRun >= 175) expLos = 1'b1;
    else if (expLos && marks >= 16 && (nBits - 1 - lastLongIdx) >= 128) expLos = 1'b0;
    check(losFlag, expLos, tag);
  endtask

  task automatic sendRun(input bit b, input int count, input string tag);
    for (int i = 0; i < count; i++) sendBit(b, tag);
  endtask

  initial begin
    #(4ns * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset, then R4 boundary at 15 and 16 marks
    doReset();
    sendRun(1'b1, 15, "R4 fewer than 16 marks");
    check(losFlag, 1'b1, "R4 15 marks keep flag");
    sendBit(1'b1, "R8 16th mark clears");
    check(losFlag, 1'b0, "R4 16 marks clear");

    // R3 restart and R2 boundary
    sendRun(1'b0, 174, "R3 run below limit");
    sendBit(1'b1, "R3 mark restarts run");
    sendRun(1'b0, 174, "R3 second short run");
    check(losFlag, 1'b0, "R3 174 spaces twice");
    sendBit(1'b0, "R2 175th space");
    check(losFlag, 1'b1, "R2 175 spaces set");

    // R5: dense marks must still wait 128 bits after the long run
    sendRun(1'b1, 127, "R5 waiting after long run");
    check(losFlag, 1'b1, "R5 127 bits after run");
    sendBit(1'b1, "R5 128th bit after run");
    check(losFlag, 1'b0, "R5 clear at 128");

    // R6: idle cycles with flag low, markIn low
    bitValid = 1'b0; markIn = 1'b0;
    repeat (300) @(negedge clk);
    check(losFlag, 1'b0, "R6 idle spaces ignored");
    sendRun(1'b0, 175, "R2 set again");

    // R6: idle marks with flag high must not clear it
    doReset();
    bitValid = 1'b0; markIn = 1'b1;
    repeat (50) @(negedge clk);
    sendRun(1'b1, 15, "R6 idle marks ignored");
    check(losFlag, 1'b1, "R6 idle marks not counted");

    // R4 / R7 density sweep, one mark every p bits
    for (int p = 6; p <= 11; p++) begin
      doReset();
      for (int i = 0; i < 600; i++) sendBit((i % p) == 0, "R4 density sweep");
      check(losFlag, (p <= 8) ? 1'b0 : 1'b1, "R4 sweep final");
    end

    // R5: run of 110 zeros while high
    doReset();
    sendRun(1'b0, 110, "R5 medium run");
    sendRun(1'b1, 127, "R5 after medium run");
    check(losFlag, 1'b1, "R5 medium run hold");
    sendBit(1'b1, "R5 medium run release");
    check(losFlag, 1'b0, "R5 medium run cleared");

    // R7: long but unsaturated runs leave the flag low
    sendRun(1'b0, 170, "R7 sparse line");
    sendBit(1'b1, "R7 single mark");
    sendRun(1'b0, 120, "R7 sparse line");
    check(losFlag, 1'b0, "R7 stays low");

    // R5: a 99-zero run imposes no wait
    doReset();
    sendRun(1'b0, 99, "R5 short run");
    sendRun(1'b1, 15, "R5 short run density");
    check(losFlag, 1'b1, "R5 15 marks after short run");
    sendBit(1'b1, "R5 16th mark after short run");
    check(losFlag, 1'b0, "R5 99 zeros no wait");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule